// File: doc/BRIEF.md
# GCI Channel Slot Slave Port

This block is the slave end of a time-division multiplexed GCI backplane. The backplane supplies a bit clock that runs at twice the data rate and an 8 kHz frame sync. Every frame is divided into 32-bit channels, and a 3-bit channel select picks one of the first eight. In each frame the block sends one 4-byte word into its channel and takes one 4-byte word out of the same channel. The word is ordered B1, B2, monitor, C/I, and every byte goes most significant bit first.

The backplane clock, frame sync and data lines are oversampled by the block's system clock. Edges are found by comparing each input with its value one clock earlier. The transmit side is a wired-AND line. The block pulls the line low for a 0 bit and releases it for a 1 bit, and it reads the line back to see whether another device is driving it. In the monitor and C/I bytes, a 1 that reads back as 0 counts as a collision. The block then goes silent until that byte ends and sets a sticky flag. If frame syncs stop arriving, the block flags loss of sync and stops driving.

Top module: `gci_slot_port`

## Requirements
- R1: After reset, `sync_loss_o` is 1 and `tx_pull_o`, `tx_active_o`, `rx_valid_o`, `contention_o` and `rx_word_o` are all 0. This state holds until the first frame sync.
- R2: On a rising edge of `fsync_i`, the next rising edge of `bclk_i` becomes bit-clock count 0 of a new frame. Each data bit spans two bit-clock periods. The channel for select value N covers counts 64·N through 64·N+63.
- R3: In the selected channel, `tx_active_o` is 1. Slot bit k carries `tx_word_i[31-k]`, so bits [31:24] are B1, [23:16] are B2, [15:8] are monitor and [7:0] are C/I. `tx_pull_o` is 1 exactly when that bit is 0. Outputs change only after a rising edge of `bclk_i` that starts a bit.
- R4: Outside the selected channel, `tx_active_o` and `tx_pull_o` are 0 (high impedance on the line). This holds whatever the line level is.
- R5: `tx_word_i` is captured at the first bit of the slot. Changes made later in the same slot do not alter the transmitted bits.
- R6: Each received bit is sampled on the second falling edge of `bclk_i` within its bit period, from `rx_data_i`. After the 32nd bit, `rx_word_o` holds the bits with the first one in bit 31, and `rx_valid_o` pulses high for exactly one clock. `rx_word_o` changes only in that clock.
- R7: In the monitor and C/I bytes, a released 1 bit that reads back 0 on `bus_sense_i` at its sampling edge causes the following. `tx_active_o` and `tx_pull_o` drop until the next byte boundary, where driving resumes. `contention_o` goes to 1 and stays there until reset.
- R8: In the B1 and B2 bytes, a low read-back level has no effect on driving or on `contention_o`.
- R9: If 800 rising bit-clock edges pass after a frame start without a new frame sync, `sync_loss_o` goes to 1 and the block stops driving. Both conditions hold until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the backplane |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Backplane bit clock, two periods per data bit |
| fsync_i | input | 1 | 8 kHz frame sync; its rising edge marks a frame start |
| chan_sel_i | input | 3 | Channel number, MSB first |
| rx_data_i | input | 1 | Receive-direction data from the backplane |
| bus_sense_i | input | 1 | Read-back of the wired-AND transmit line |
| tx_word_i | input | 32 | Word to send: B1, B2, monitor, C/I from MSB down |
| tx_pull_o | output | 1 | 1 pulls the transmit line low |
| tx_active_o | output | 1 | 1 while the block owns and drives its slot |
| rx_word_o | output | 32 | Last complete received slot word |
| rx_valid_o | output | 1 | One-clock pulse when `rx_word_o` is updated |
| contention_o | output | 1 | Sticky collision flag |
| sync_loss_o | output | 1 | 1 when no valid frame timing is held |

## Verification
Some properties are checked on every clock. A pull never happens without ownership of the slot. The valid strobe is a single clock wide, and the received word moves only with it. The collision flag never clears. The block stays silent once sync loss has settled. Other behaviour can only be shown by the bench scenarios, which compare against a bit-clock-level model. These cover slot placement for several channel numbers, bit order and sampling edges, the capture point of the transmit word, back-off confined to one byte, immunity in B1/B2, resync by an early frame sync, and time-out then reacquisition.

// File: rtl/gci_pkg.sv
package gci_pkg;
   localparam int unsigned BYTE_W       = 8;
   localparam int unsigned BCLK_PER_BIT = 2;

   typedef struct packed {
      logic rise;
      logic fall;
   } gci_edges_t;

   function automatic int unsigned slot_bits(input int unsigned nbytes);
      return nbytes * BYTE_W;
   endfunction
endpackage

// File: rtl/gci_bit_timer.sv
module gci_bit_timer #(
   parameter int unsigned CNT_W     = 10,
   parameter int unsigned LOS_BCLKS = 800,
   parameter int unsigned SMP_W     = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bclk_i,
   input  logic                   fsync_i,
   input  logic [SMP_W-1:0]       smp_i,
   output gci_pkg::gci_edges_t    edges_o,
   output logic [CNT_W-1:0]       cnt_o,
   output logic                   locked_o,
   output logic [SMP_W-1:0]       smp_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOS_BCLKS - 1);

   logic bclk_q, fs_q, fs_arm;
   logic b_rise, b_fall, fs_rise, start;

   assign b_rise  = bclk_i & ~bclk_q;
   assign b_fall  = ~bclk_i & bclk_q;
   assign fs_rise = fsync_i & ~fs_q;
   assign start   = fs_arm | fs_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q   <= 1'b0;
         fs_q     <= 1'b0;
         fs_arm   <= 1'b0;
         edges_o  <= '0;
         cnt_o    <= '0;
         locked_o <= 1'b0;
         smp_o    <= '0;
      end else begin
         bclk_q       <= bclk_i;
         fs_q         <= fsync_i;
         edges_o.rise <= b_rise;
         edges_o.fall <= b_fall;
         if (b_fall) smp_o <= smp_i;
         if (b_rise)       fs_arm <= 1'b0;
         else if (fs_rise) fs_arm <= 1'b1;
         if (b_rise) begin
            if (start) begin
               cnt_o    <= '0;
               locked_o <= 1'b1;
            end else if (locked_o) begin
               if (cnt_o == LAST) locked_o <= 1'b0;
               else               cnt_o    <= cnt_o + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/gci_slot_tx.sv
module gci_slot_tx #(
   parameter int unsigned SLOT_BYTES = 4,
   parameter int unsigned CHK_BYTES  = 2,
   localparam int unsigned SLOT_W    = gci_pkg::slot_bits(SLOT_BYTES),
   localparam int unsigned SB_W      = $clog2(SLOT_W),
   localparam int unsigned BI_W      = $clog2(SLOT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_p,
   input  logic              fall_p,
   input  logic              in_slot,
   input  logic              phase,
   input  logic [SB_W-1:0]   slot_bit,
   input  logic [SLOT_W-1:0] tx_word,
   input  logic              bus_d,
   output logic              pull_o,
   output logic              active_o,
   output logic              contention_o
);
   logic [SLOT_W-1:0] shreg;
   logic              cur_bit, backoff;
   logic              first, byte_edge, bit_now, bo_now, chk_byte;
   logic [BI_W-1:0]   byte_idx;

   assign byte_idx  = slot_bit[SB_W-1:3];
   assign first     = (slot_bit == '0);
   assign byte_edge = (slot_bit[2:0] == 3'd0);
   assign bit_now   = first ? tx_word[SLOT_W-1] : shreg[SLOT_W-1];
   assign bo_now    = byte_edge ? 1'b0 : backoff;

   generate
      if (CHK_BYTES >= SLOT_BYTES) begin : g_chk_all
         assign chk_byte = 1'b1;
      end else begin : g_chk_tail
         assign chk_byte = (byte_idx >= BI_W'(SLOT_BYTES - CHK_BYTES));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg        <= '0;
         cur_bit      <= 1'b0;
         backoff      <= 1'b0;
         pull_o       <= 1'b0;
         active_o     <= 1'b0;
         contention_o <= 1'b0;
      end else if (rise_p) begin
         if (!in_slot) begin
            backoff  <= 1'b0;
            pull_o   <= 1'b0;
            active_o <= 1'b0;
         end else if (!phase) begin
            shreg    <= first ? (tx_word << 1) : (shreg << 1);
            cur_bit  <= bit_now;
            backoff  <= bo_now;
            active_o <= ~bo_now;
            pull_o   <= ~bo_now & ~bit_now;
         end
      end else if (fall_p && in_slot && phase && chk_byte &&
                   active_o && cur_bit && !bus_d) begin
         backoff      <= 1'b1;
         active_o     <= 1'b0;
         pull_o       <= 1'b0;
         contention_o <= 1'b1;
      end
   end
endmodule

// File: rtl/gci_slot_rx.sv
module gci_slot_rx #(
   parameter int unsigned SLOT_W = 32,
   localparam int unsigned SB_W  = $clog2(SLOT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_p,
   input  logic              in_slot,
   input  logic              phase,
   input  logic [SB_W-1:0]   slot_bit,
   input  logic              rx_d,
   output logic [SLOT_W-1:0] word_o,
   output logic              valid_o
);
   logic [SLOT_W-1:0] shreg;
   logic [SLOT_W-1:0] shreg_nx;
   logic              take;

   assign shreg_nx = {shreg[SLOT_W-2:0], rx_d};
   assign take     = fall_p & in_slot & phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         word_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (take) begin
            shreg <= shreg_nx;
            if (slot_bit == SB_W'(SLOT_W - 1)) begin
               word_o  <= shreg_nx;
               valid_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/gci_slot_port.sv
module gci_slot_port #(
   parameter int unsigned CHAN_W     = 3,
   parameter int unsigned SLOT_BYTES = 4,
   parameter int unsigned CHK_BYTES  = 2,
   parameter int unsigned LOS_BCLKS  = 800,
   localparam int unsigned SLOT_W    = gci_pkg::slot_bits(SLOT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_i,
   input  logic              fsync_i,
   input  logic [CHAN_W-1:0] chan_sel_i,
   input  logic              rx_data_i,
   input  logic              bus_sense_i,
   input  logic [SLOT_W-1:0] tx_word_i,
   output logic              tx_pull_o,
   output logic              tx_active_o,
   output logic [SLOT_W-1:0] rx_word_o,
   output logic              rx_valid_o,
   output logic              contention_o,
   output logic              sync_loss_o
);
   localparam int unsigned SB_W     = $clog2(SLOT_W);
   localparam int unsigned CNT_W    = $clog2(LOS_BCLKS);
   localparam int unsigned IDX_W    = CNT_W - SB_W - 1;
   localparam int unsigned SLOT_BCK = gci_pkg::BCLK_PER_BIT * SLOT_W;

   generate
      if ((SLOT_BYTES < 2) || ((SLOT_BYTES & (SLOT_BYTES - 1)) != 0)) begin : g_bad_bytes
         $error("SLOT_BYTES must be a power of two, at least 2");
      end
      if (CHK_BYTES > SLOT_BYTES) begin : g_bad_chk
         $error("CHK_BYTES exceeds SLOT_BYTES");
      end
      if (LOS_BCLKS <= SLOT_BCK * (1 << CHAN_W)) begin : g_bad_los
         $error("LOS_BCLKS must exceed the span of all selectable channels");
      end
   endgenerate

   gci_pkg::gci_edges_t edges;
   logic [CNT_W-1:0]    cnt;
   logic                locked;
   logic [1:0]          smp;
   logic [IDX_W-1:0]    slot_idx;
   logic [SB_W-1:0]     slot_bit;
   logic                phase, in_slot;

   gci_bit_timer #(.CNT_W(CNT_W), .LOS_BCLKS(LOS_BCLKS), .SMP_W(2)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_i   (bclk_i),
      .fsync_i  (fsync_i),
      .smp_i    ({rx_data_i, bus_sense_i}),
      .edges_o  (edges),
      .cnt_o    (cnt),
      .locked_o (locked),
      .smp_o    (smp)
   );

   assign slot_idx    = cnt[CNT_W-1:SB_W+1];
   assign slot_bit    = cnt[SB_W:1];
   assign phase       = cnt[0];
   assign in_slot     = locked && (slot_idx == IDX_W'(chan_sel_i));
   assign sync_loss_o = ~locked;

   gci_slot_tx #(.SLOT_BYTES(SLOT_BYTES), .CHK_BYTES(CHK_BYTES)) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .rise_p       (edges.rise),
      .fall_p       (edges.fall),
      .in_slot      (in_slot),
      .phase        (phase),
      .slot_bit     (slot_bit),
      .tx_word      (tx_word_i),
      .bus_d        (smp[0]),
      .pull_o       (tx_pull_o),
      .active_o     (tx_active_o),
      .contention_o (contention_o)
   );

   gci_slot_rx #(.SLOT_W(SLOT_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_p   (edges.fall),
      .in_slot  (in_slot),
      .phase    (phase),
      .slot_bit (slot_bit),
      .rx_d     (smp[1]),
      .word_o   (rx_word_o),
      .valid_o  (rx_valid_o)
   );
endmodule

// File: rtl/gci_slot_port_chk.sv
module gci_slot_port_chk #(
   parameter int unsigned SLOT_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_pull_o,
   input logic              tx_active_o,
   input logic              rx_valid_o,
   input logic              contention_o,
   input logic              sync_loss_o,
   input logic [SLOT_W-1:0] rx_word_o
);
   // R3: the line is only pulled while the slot is owned
   p_pull_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pull_o |-> tx_active_o);

   // R9: once loss of sync has settled, nothing is driven
   p_silent_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_loss_o && $past(sync_loss_o)) |-> !tx_active_o);

   // R6: the valid strobe lasts one clock
   p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   // R6: the received word only moves together with the strobe
   p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_word_o) |-> rx_valid_o);

   // R7: the collision flag never clears
   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      contention_o |=> contention_o);
endmodule

bind gci_slot_port gci_slot_port_chk #(.SLOT_W(SLOT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_pull_o    (tx_pull_o),
   .tx_active_o  (tx_active_o),
   .rx_valid_o   (rx_valid_o),
   .contention_o (contention_o),
   .sync_loss_o  (sync_loss_o),
   .rx_word_o    (rx_word_o)
);

// File: tb/gci_slot_port_tb_top.sv
module gci_slot_port_tb_top;
   localparam int LOS = 800;

   logic        clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fsync = 1'b0;
   logic        rx_data = 1'b1, other_lvl = 1'b1;
   logic [2:0]  sel = 3'd0;
   logic [31:0] tx_word = '0;
   logic        tx_pull, tx_active, rx_valid, contention, sync_loss;
   logic [31:0] rx_word;
   wire         bus_sense = other_lvl & ~tx_pull;

   gci_slot_port dut_i (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync),
      .chan_sel_i(sel), .rx_data_i(rx_data), .bus_sense_i(bus_sense),
      .tx_word_i(tx_word), .tx_pull_o(tx_pull), .tx_active_o(tx_active),
      .rx_word_o(rx_word), .rx_valid_o(rx_valid),
      .contention_o(contention), .sync_loss_o(sync_loss));

   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0, valid_cyc = -10;
   bit done = 1'b0;
   logic [31:0] exp_word = '0;
   string tag = "R2 R3 R4";

   // bit-clock level reference model
   int          m_cnt = 0;
   bit          m_lock = 0, m_bo = 0, m_bit = 0, e_act = 0, e_pull = 0, m_cont = 0;
   logic [31:0] m_tx = '0, m_rx = '0;
   logic [31:0] rx_pat = '0, cont_mask = '0;
   logic [2:0]  nx_sel = '0;
   logic [31:0] nx_tx = '0, nx_rx = '0, nx_mask = '0;
   int          chg_cnt = -1;
   logic [31:0] chg_val = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
      if (rst_n) begin
         chk("R6 valid strobe", {31'd0, rx_valid}, {31'd0, cyc == valid_cyc});
         if (cyc == valid_cyc) chk("R6 received word", rx_word, exp_word);
      end
   endtask

   task automatic bclk_cycle(input bit fs_now);
      int sb;
      bit in_slot;
      step();
      if (fs_now) begin
         sel = nx_sel; tx_word = nx_tx; rx_pat = nx_rx; cont_mask = nx_mask;
      end
      bclk = 1'b1;
      fsync = fs_now;
      if (fs_now) begin m_cnt = 0; m_lock = 1; end
      else if (m_lock) begin
         if (m_cnt == LOS - 1) m_lock = 0;
         else m_cnt++;
      end
      in_slot = m_lock && ((m_cnt / 64) == int'(sel));
      sb = (m_cnt % 64) / 2;
      if (!in_slot) begin
         e_act = 0; e_pull = 0; m_bo = 0;
      end else if (m_cnt % 2 == 0) begin
         if (sb == 0) m_tx = tx_word;
         m_bit = m_tx[31-sb];
         if (sb % 8 == 0) m_bo = 0;
         e_act = !m_bo;
         e_pull = !m_bo && !m_bit;
      end
      rx_data = in_slot ? rx_pat[31-sb] : logic'((m_cnt / 2) % 2);
      other_lvl = in_slot ? !cont_mask[31-sb] : logic'(m_cnt % 3 != 0);
      step();
      step();
      chk({tag, " pull"}, {31'd0, tx_pull}, {31'd0, e_pull});
      chk({tag, " active"}, {31'd0, tx_active}, {31'd0, e_act});
      chk("R9 sync loss", {31'd0, sync_loss}, {31'd0, !m_lock});
      chk("R7 contention flag", {31'd0, contention}, {31'd0, m_cont});
      bclk = 1'b0;
      if (in_slot && (m_cnt % 2 == 1)) begin
         m_rx = {m_rx[30:0], rx_data};
         if (sb == 31) begin valid_cyc = cyc + 2; exp_word = m_rx; end
         if (sb >= 16 && e_act && m_bit && !other_lvl) begin
            m_bo = 1; e_act = 0; e_pull = 0; m_cont = 1;
         end
      end
      step();
      if (m_cnt == chg_cnt) tx_word = chg_val;
   endtask

   task automatic run_frame(input logic [2:0] s, input logic [31:0] t,
                            input logic [31:0] r, input logic [31:0] m, input int len);
      nx_sel = s; nx_tx = t; nx_rx = r; nx_mask = m;
      bclk_cycle(1'b1);
      for (int i = 1; i < len; i++) bclk_cycle(1'b0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 sync loss", {31'd0, sync_loss}, 32'd1);
      chk("R1 pull", {31'd0, tx_pull}, 32'd0);
      chk("R1 active", {31'd0, tx_active}, 32'd0);
      chk("R1 valid", {31'd0, rx_valid}, 32'd0);
      chk("R1 contention", {31'd0, contention}, 32'd0);
      chk("R1 word", rx_word, 32'd0);
      tag = "R1 R4";
      for (int i = 0; i < 20; i++) bclk_cycle(1'b0);

      tag = "R2 R3 R4";
      run_frame(3'd0, 32'hA5C3_0FF0, 32'h1234_5678, 32'h0, 200);  // cut short
      run_frame(3'd0, 32'h9A3C_55E1, 32'hCAFE_F00D, 32'h0, 512);  // R2 resync
      tag = "R5";
      chg_cnt = 5 * 64 + 10; chg_val = 32'h0F0F_0F0F;
      run_frame(3'd5, 32'hF0E1_D2C3, 32'h8001_7FFE, 32'h0, 512);
      chg_cnt = -1;
      tag = "R3 R4";
      run_frame(3'd7, 32'h0000_FFFF, 32'hFFFF_0000, 32'h0, 512);
      tag = "R7 R8";
      run_frame(3'd2, 32'hA5FF_FF3C, 32'h3C3C_A5A5, 32'h0020_2080, 512);
      tag = "R9";
      for (int i = 0; i < 330; i++) bclk_cycle(1'b0);
      chk("R9 timed out", {31'd0, sync_loss}, 32'd1);
      chk("R9 not driving", {31'd0, tx_active}, 32'd0);
      tag = "R9 R3";
      run_frame(3'd3, 32'h6DB6_DB6D, 32'h0123_4567, 32'h0, 512);
      chk("R7 flag kept", {31'd0, contention}, 32'd1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule